// File: doc/BRIEF.md
# Transactional Output Commit Buffer

This block sits between a processor and an output peripheral in a node of a redundant computer pair. Software opens a transaction with an open strobe and then writes output words. The block holds those words and does not forward any of them until the transaction is closed successfully. A close strobe commits the held words, and they then drain to the peripheral over a ready/valid stream in the order they were written.

A cancel strobe throws away everything written since the open. A role-switch event from the switchover logic does the same if it arrives while the transaction is still open. After a role switch, the new master can therefore run the whole transaction again from its first step, and the peripheral never sees part of a transaction. A role switch that arrives after the close does not stop delivery.

The buffer holds one transaction at a time, and its capacity is a parameter. While committed words are draining, a new open strobe is refused and the busy output is high. An overflow sets a sticky flag, and that flag forces the transaction to be discarded at close. Strobes that arrive outside an open transaction are flagged on a one-cycle protocol-error pulse.

Top module: `txn_commit_buf`

## Requirements
- R1: While a transaction is open, out_valid stays low. A rising edge of out_valid only follows a cycle in which txn_close was high.
- R2: When txn_close is high in the open state, and the transaction has at least one word and no overflow, the state changes to draining. out_valid is high from the next cycle. The words are delivered in write order, and a write in the same cycle as the close is included. A word is consumed when out_valid and out_ready are both high at a rising clock edge. After the last word, out_valid drops in the following cycle.
- R3: txn_cancel in the open state discards every held word, including a write in the same cycle. The block returns to idle, and no word of that transaction appears on the output.
- R4: role_swap in the open state has the same effect as txn_cancel.
- R5: role_swap and txn_cancel during draining have no effect. Every committed word is still delivered, in order.
- R6: busy is high exactly while committed words are draining. A txn_open during that time is ignored, and the drain continues unchanged.
- R7: If txn_wr arrives while DEPTH words are already held, the word is dropped. ovf_flag goes high in the next cycle and stays high until the next accepted txn_open. A close on an overflowed transaction discards it with no output.
- R8: proto_err pulses high for one cycle, in the cycle after txn_wr or txn_close arrives while no transaction is open (idle or draining). It also pulses after txn_open arrives while a transaction is already open. Such a write or close changes nothing else.
- R9: After reset, out_valid, busy, ovf_flag and proto_err are all low.
- R10: A close on an open transaction with no words returns the block to idle without asserting out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_open | input | 1 | Open-transaction strobe |
| txn_wr | input | 1 | Write strobe for txn_wdata |
| txn_wdata | input | DATA_W | Output word to hold |
| txn_close | input | 1 | Commit strobe |
| txn_cancel | input | 1 | Abort strobe |
| role_swap | input | 1 | Role-switch event from the switchover logic |
| out_valid | output | 1 | Committed word available |
| out_data | output | DATA_W | Committed word |
| out_ready | input | 1 | Peripheral accepts the word |
| busy | output | 1 | Draining; txn_open is refused |
| ovf_flag | output | 1 | Sticky overflow of the current transaction |
| proto_err | output | 1 | One-cycle protocol-error pulse |

## Verification
The bench builds the block with DEPTH=4 and DATA_W=8. With the small depth, the bench can fill the buffer exactly, add one more write to reach overflow, and test the overflow together with a close in the same cycle, all in a few cycles. It also drains with a stalling out_ready pattern. A role switch or a cancel in the middle of a drain therefore meets words that are still waiting. The bench also checks a close with zero words and a write in the same cycle as a close.

// File: rtl/txn_cb_pkg.sv
`timescale 1ns/1ps
package txn_cb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_OPEN  = 2'd1,
      ST_DRAIN = 2'd2
   } txn_state_e;
endpackage

// File: rtl/txn_store.sv
`timescale 1ns/1ps
module txn_store #(
   parameter int  DATA_W    = 16,
   parameter int  DEPTH     = 8,
   parameter bit  CLEAR_MEM = 1'b0,
   localparam int ADDR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (CLEAR_MEM) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];
endmodule

// File: rtl/txn_seq.sv
`timescale 1ns/1ps
module txn_seq
   import txn_cb_pkg::*;
#(
   parameter int  DEPTH  = 8,
   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_i,
   input  logic              wr_i,
   input  logic              close_i,
   input  logic              cancel_i,
   input  logic              swap_i,
   input  logic              ready_i,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [ADDR_W-1:0] mem_raddr,
   output logic              valid_o,
   output logic              busy_o,
   output logic              ovf_o,
   output logic              perr_o
);
   txn_state_e        state;
   logic [CNT_W-1:0]  fill;
   logic [ADDR_W-1:0] rptr;
   logic              ovf_q, perr_q;

   logic             in_open, in_drain, abort_now, room, ovf_next;
   logic             pop, last_pop, perr_now;
   logic [CNT_W-1:0] fill_after;

   assign in_open    = (state == ST_OPEN);
   assign in_drain   = (state == ST_DRAIN);
   assign abort_now  = in_open && (cancel_i || swap_i);
   assign room       = (fill < CNT_W'(DEPTH));
   assign mem_we     = in_open && wr_i && !abort_now && room;
   assign ovf_next   = ovf_q || (in_open && wr_i && !abort_now && !room);
   assign fill_after = fill + CNT_W'(mem_we);
   assign pop        = in_drain && ready_i;
   assign last_pop   = pop && ((CNT_W'(rptr) + CNT_W'(1)) == fill);
   assign perr_now   = (!in_open && (wr_i || close_i)) || (in_open && open_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         fill   <= '0;
         rptr   <= '0;
         ovf_q  <= 1'b0;
         perr_q <= 1'b0;
      end else begin
         perr_q <= perr_now;
         ovf_q  <= ovf_next;
         unique case (state)
            ST_IDLE: begin
               if (open_i) begin
                  state <= ST_OPEN;
                  fill  <= '0;
                  rptr  <= '0;
                  ovf_q <= 1'b0;
               end
            end
            ST_OPEN: begin
               if (abort_now) begin
                  state <= ST_IDLE;
                  fill  <= '0;
               end else if (close_i) begin
                  if (ovf_next || (fill_after == '0)) begin
                     state <= ST_IDLE;
                     fill  <= '0;
                  end else begin
                     state <= ST_DRAIN;
                     fill  <= fill_after;
                     rptr  <= '0;
                  end
               end else begin
                  fill <= fill_after;
               end
            end
            ST_DRAIN: begin
               if (last_pop) begin
                  state <= ST_IDLE;
                  fill  <= '0;
                  rptr  <= '0;
               end else if (pop) begin
                  rptr <= rptr + ADDR_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_waddr = fill[ADDR_W-1:0];
   assign mem_raddr = rptr;
   assign valid_o   = in_drain;
   assign busy_o    = in_drain;
   assign ovf_o     = ovf_q;
   assign perr_o    = perr_q;

   // R1
   commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> $past(close_i));

   // R2
   hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(mem_raddr)));

   // R5
   swap_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_drain && (swap_i || cancel_i) && !ready_i) |=> in_drain);

   // R6
   no_open_from_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_drain |=> (state != ST_OPEN));

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !open_i) |=> ovf_o);

   // R8
   stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_IDLE) && (wr_i || close_i)) |=> perr_o);
endmodule

// File: rtl/txn_commit_buf.sv
`timescale 1ns/1ps
module txn_commit_buf #(
   parameter int  DATA_W    = 16,
   parameter int  DEPTH     = 8,
   parameter bit  CLEAR_MEM = 1'b0,
   localparam int ADDR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_open,
   input  logic              txn_wr,
   input  logic [DATA_W-1:0] txn_wdata,
   input  logic              txn_close,
   input  logic              txn_cancel,
   input  logic              role_swap,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready,
   output logic              busy,
   output logic              ovf_flag,
   output logic              proto_err
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("txn_commit_buf: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("txn_commit_buf: DATA_W must be positive");
      end
   endgenerate

   logic              we;
   logic [ADDR_W-1:0] waddr, raddr;

   txn_seq #(.DEPTH(DEPTH)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_i    (txn_open),
      .wr_i      (txn_wr),
      .close_i   (txn_close),
      .cancel_i  (txn_cancel),
      .swap_i    (role_swap),
      .ready_i   (out_ready),
      .mem_we    (we),
      .mem_waddr (waddr),
      .mem_raddr (raddr),
      .valid_o   (out_valid),
      .busy_o    (busy),
      .ovf_o     (ovf_flag),
      .perr_o    (proto_err)
   );

   txn_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CLEAR_MEM(CLEAR_MEM)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .waddr (waddr),
      .wdata (txn_wdata),
      .raddr (raddr),
      .rdata (out_data)
   );
endmodule

// File: tb/txn_commit_buf_test.sv
`timescale 1ns/1ps
module txn_commit_buf_test;
   localparam int DW = 8;
   localparam int DP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          t_open = 0, t_wr = 0, t_close = 0, t_cancel = 0, t_swap = 0;
   logic [DW-1:0] t_data = '0;
   logic          out_ready = 1'b1;
   logic          out_valid, busy, ovf_flag, proto_err;
   logic [DW-1:0] out_data;

   int    checks = 0, fails = 0, cyc = 0;
   bit    slow = 0, done = 0;
   string tag = "R9 reset";

   int            ms = 0;
   bit            movf = 0, mperr = 0;
   logic [DW-1:0] hold[$];
   logic [DW-1:0] outq[$];

   always #4 clk = ~clk;

   txn_commit_buf #(.DATA_W(DW), .DEPTH(DP)) uut (
      .clk(clk), .rst_n(rst_n), .txn_open(t_open), .txn_wr(t_wr),
      .txn_wdata(t_data), .txn_close(t_close), .txn_cancel(t_cancel),
      .role_swap(t_swap), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready), .busy(busy), .ovf_flag(ovf_flag),
      .proto_err(proto_err));

   always @(posedge clk) begin
      #2;
      cyc++;
      out_ready = slow ? ((cyc % 3) == 0) : 1'b1;
   end

   always @(posedge clk) begin
      bit np;
      np = 0;
      if (!rst_n) begin
         ms = 0; movf = 0; mperr = 0;
         hold.delete(); outq.delete();
      end else begin
         case (ms)
            0: begin
               if (t_open) begin hold.delete(); movf = 0; ms = 1; end
               if (t_wr || t_close) np = 1;
            end
            1: begin
               if (t_open) np = 1;
               if (t_cancel || t_swap) begin
                  hold.delete(); ms = 0;
               end else begin
                  if (t_wr) begin
                     if (hold.size() < DP) hold.push_back(t_data);
                     else movf = 1;
                  end
                  if (t_close) begin
                     if (movf || hold.size() == 0) begin
                        hold.delete(); ms = 0;
                     end else begin
                        outq = hold; hold.delete(); ms = 2;
                     end
                  end
               end
            end
            default: begin
               if (t_wr || t_close) np = 1;
               if (out_ready) begin
                  void'(outq.pop_front());
                  if (outq.size() == 0) ms = 0;
               end
            end
         endcase
         mperr = np;
      end
   end

   task automatic chk(string nm, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: %s actual=%0h expected=%0h at cycle %0d", tag, nm, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk("out_valid", DW'(out_valid), DW'(ms == 2));
         if (ms == 2) chk("out_data order", out_data, outq[0]);
         chk("busy", DW'(busy), DW'(ms == 2));
         chk("ovf_flag", DW'(ovf_flag), DW'(movf));
         chk("proto_err", DW'(proto_err), DW'(mperr));
      end
   end

   task automatic drive(bit o, bit w, logic [DW-1:0] d, bit c, bit x, bit s);
      @(posedge clk); #2;
      t_open = o; t_wr = w; t_data = d; t_close = c; t_cancel = x; t_swap = s;
   endtask

   task automatic nop(int n);
      for (int i = 0; i < n; i++) drive(0, 0, '0, 0, 0, 0);
   endtask

   task automatic wr(logic [DW-1:0] d);
      drive(0, 1, d, 0, 0, 0);
   endtask

   initial begin
      #(8 * 20000);
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      nop(2);

      tag = "R8 write and close while idle";
      wr(8'h11); drive(0, 0, '0, 1, 0, 0); nop(2);

      tag = "R2 commit three words in order";
      drive(1, 0, '0, 0, 0, 0); wr(8'hA1); wr(8'hA2); wr(8'hA3);
      drive(0, 0, '0, 1, 0, 0); nop(6);

      tag = "R2 write in same cycle as close";
      drive(1, 0, '0, 0, 0, 0); wr(8'hB1); drive(0, 1, 8'hB2, 1, 0, 0); nop(5);

      tag = "R10 empty close";
      drive(1, 0, '0, 0, 0, 0); drive(0, 0, '0, 1, 0, 0); nop(3);

      tag = "R3 cancel discards";
      drive(1, 0, '0, 0, 0, 0); wr(8'hC1); wr(8'hC2);
      drive(0, 1, 8'hC3, 0, 1, 0); nop(4);

      tag = "R4 role switch while open discards";
      drive(1, 0, '0, 0, 0, 0); wr(8'hD1); wr(8'hD2);
      drive(0, 0, '0, 0, 0, 1); drive(0, 0, '0, 1, 0, 0); nop(3);

      tag = "R5 role switch and cancel during slow drain";
      slow = 1;
      drive(1, 0, '0, 0, 0, 0); wr(8'hE1); wr(8'hE2); wr(8'hE3); wr(8'hE4);
      drive(0, 0, '0, 1, 0, 0); nop(1);
      drive(0, 0, '0, 0, 0, 1); nop(1); drive(0, 0, '0, 0, 1, 0);
      tag = "R6 open refused while busy";
      drive(1, 0, '0, 0, 0, 0); drive(0, 1, 8'hEE, 0, 0, 0); nop(14);
      slow = 0;

      tag = "R7 overflow forces discard";
      drive(1, 0, '0, 0, 0, 0); wr(8'hF1); wr(8'hF2); wr(8'hF3); wr(8'hF4);
      wr(8'hF5); nop(2); drive(0, 0, '0, 1, 0, 0); nop(3);
      tag = "R7 overflow cleared on next open";
      drive(1, 0, '0, 0, 0, 0); wr(8'h71); drive(0, 0, '0, 1, 0, 0); nop(3);

      tag = "R7 overflow in same cycle as close";
      drive(1, 0, '0, 0, 0, 0); wr(8'h81); wr(8'h82); wr(8'h83); wr(8'h84);
      drive(0, 1, 8'h85, 1, 0, 0); nop(3);

      tag = "R8 open while open";
      drive(1, 0, '0, 0, 0, 0); wr(8'h91); drive(1, 0, '0, 0, 0, 0);
      drive(0, 0, '0, 1, 0, 0); nop(4);

      tag = "R1 held words stay hidden";
      drive(1, 0, '0, 0, 0, 0); wr(8'h55); nop(3);
      drive(0, 0, '0, 1, 0, 0); nop(4);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule